// File: doc/BRIEF.md
# Strobe-Gated DDR Input Deserializer

This block captures a source-synchronous input group: a set of data pins that travel with a strobe. The strobe reaches the block as a level sampled in the core clock domain, and both of its transitions mark a data slice. A gating enable defines the window in which strobe transitions are accepted. Transitions outside that window, such as preamble and postamble ringing, never capture anything. Each window also has a fixed budget of edges, so a stray trailing transition cannot add a slice.

Accepted slices are packed into core-rate words of several slices, earliest slice in the low bits. A finished word is written into a small read FIFO on the same clock edge as its last slice. The core pops words with a read enable and gets them one cycle later with a valid flag. A single-data-rate mode keeps only every other accepted slice.

Top module: `strobe_capture_deser`

## Requirements
- R1: After reset, `fifo_empty`=1, `fifo_full`=0, `overflow`=0, `rd_valid`=0 and `rd_data`=0.
- R2: A strobe transition (a change of `strobe_in` between consecutive clock samples) taken while `gate_en` is low captures nothing. The FIFO content is unchanged by it.
- R3: A low-to-high change of `gate_en` opens a window that accepts at most `BURST_EDGES` strobe transitions (default 2*SLICES). Further transitions are ignored until `gate_en` falls and rises again.
- R4: In DDR mode (`sdr_mode`=0) every accepted transition captures `pin_data` as one slice, rising and falling alike. With the strobe idle low at the window start, the rising-edge slice comes first.
- R5: Slice k of a word (k counted from 0 in arrival order) occupies `rd_data[k*PINS +: PINS]`. The earliest slice is therefore in the least significant bits.
- R6: In SDR mode (`sdr_mode`=1) the 1st, 3rd, 5th, ... accepted transitions of a window are kept as slices and the others are dropped.
- R7: A word is written into the FIFO on the same clock edge that captures its last slice. `fifo_empty` falls at that edge.
- R8: When `rd_en` is high at a clock edge and the FIFO is not empty, the oldest word appears on `rd_data` with `rd_valid`=1 after that edge. Otherwise `rd_valid`=0 and `rd_data` holds its value.
- R9: The FIFO holds `DEPTH` words, and `fifo_full` is high when all of them are used. A word completed while the FIFO is full and not being read is dropped and sets `overflow`, which stays high until reset.
- R10: Opening a new window discards any incomplete word from the previous window. Slice counting restarts at slice 0, and the SDR keep/drop phase restarts with "keep".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; samples strobe and data |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_in | input | 1 | Sampled input strobe level |
| gate_en | input | 1 | Strobe gating enable; its rising edge opens a window |
| sdr_mode | input | 1 | 1 = keep every other accepted slice |
| pin_data | input | PINS | Data pins sampled with the strobe |
| rd_en | input | 1 | Pop request from the core |
| rd_data | output | PINS*SLICES | Popped word, earliest slice in LSBs |
| rd_valid | output | 1 | rd_data was updated by a pop on the previous edge |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| overflow | output | 1 | Sticky: a completed word was dropped |

## Verification
The bench builds the block with 4 pins, 4 slices per word, a 4-word FIFO and an 8-edge window budget. With these values a single window yields exactly two words. A longer burst overruns the budget in a way that would show as a third word. Six back-to-back words without reads are enough to reach the full and overflow conditions. Odd-length bursts leave partial words behind, so their discard at the next window opening can be observed, and SDR bursts produce a word from alternating slices.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  // one sampled strobe transition, split by direction
  typedef struct packed {
    logic rise;
    logic fall;
  } strobe_ev_t;
endpackage

// File: rtl/sgd_gate.sv
module sgd_gate
  import sgd_pkg::*;
#(
  parameter int BURST_EDGES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  input  logic gate_en,
  output logic take,
  output logic restart
);
  localparam int CW = $clog2(BURST_EDGES + 1);
  localparam logic [CW-1:0] BUDGET = CW'(BURST_EDGES);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic          strobe_q, gate_q;
  logic [CW-1:0] left_q, left_d;
  strobe_ev_t    ev;
  logic          window;

  always_comb begin
    ev.rise = strobe_in & ~strobe_q;
    ev.fall = ~strobe_in & strobe_q;
    restart = gate_en & ~gate_q;
    window  = gate_en & (restart | (left_q != '0));
    take    = window & (ev.rise | ev.fall);
    left_d  = left_q;
    if (!gate_en)      left_d = '0;
    else if (restart)  left_d = take ? (BUDGET - ONE) : BUDGET;
    else if (take)     left_d = left_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      gate_q   <= 1'b0;
      left_q   <= '0;
    end else begin
      strobe_q <= strobe_in;
      gate_q   <= gate_en;
      left_q   <= left_d;
    end
  end
endmodule

// File: rtl/sgd_assemble.sv
module sgd_assemble #(
  parameter int PINS   = 4,
  parameter int SLICES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   take,
  input  logic                   restart,
  input  logic                   sdr_mode,
  input  logic [PINS-1:0]        pin_data,
  output logic                   push,
  output logic [PINS*SLICES-1:0] push_word
);
  localparam int W  = PINS * SLICES;
  localparam int SW = (SLICES > 1) ? $clog2(SLICES) : 1;
  localparam logic [SW-1:0] LAST = SW'(SLICES - 1);
  localparam logic [SW-1:0] ONE  = SW'(1);

  logic [SW-1:0] slot_q, slot_d, slot_cur;
  logic          odd_q, odd_d, odd_cur;
  logic [W-1:0]  word_q, merged;
  logic          keep;

  always_comb begin
    slot_cur = restart ? '0   : slot_q;
    odd_cur  = restart ? 1'b0 : odd_q;
    keep     = take & ~(sdr_mode & odd_cur);
    push     = keep & (slot_cur == LAST);
    slot_d   = slot_cur;
    if (keep) slot_d = (slot_cur == LAST) ? '0 : (slot_cur + ONE);
    odd_d    = take ? ~odd_cur : odd_cur;
  end

  // place the incoming slice into its slot, earliest slot lowest
  for (genvar g = 0; g < SLICES; g++) begin : g_slot
    assign merged[g*PINS +: PINS] =
      (slot_cur == SW'(g)) ? pin_data : word_q[g*PINS +: PINS];
  end

  assign push_word = merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      odd_q  <= 1'b0;
    end else begin
      slot_q <= slot_d;
      odd_q  <= odd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (keep)  word_q <= merged;
  end
endmodule

// File: rtl/sgd_rfifo.sv
module sgd_rfifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_word,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  output logic         empty,
  output logic         full,
  output logic         overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LASTA = AW'(DEPTH - 1);
  localparam logic [AW-1:0] ONEA  = AW'(1);
  localparam logic [CW-1:0] ONEC  = CW'(1);
  localparam logic [CW-1:0] CAP   = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop, wr, ovf_set;

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == CAP);
    pop     = rd_en & ~empty;
    wr      = push & (~full | pop);
    ovf_set = push & full & ~pop;
    wp_d    = wr  ? ((wp_q == LASTA) ? '0 : (wp_q + ONEA)) : wp_q;
    rp_d    = pop ? ((rp_q == LASTA) ? '0 : (rp_q + ONEA)) : rp_q;
    case ({wr, pop})
      2'b10:   cnt_d = cnt_q + ONEC;
      2'b01:   cnt_d = cnt_q - ONEC;
      default: cnt_d = cnt_q;
    endcase
  end

  // storage without reset; each entry has its own write enable
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr && (wp_q == AW'(e))) mem[e] <= push_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q     <= '0;
      rp_q     <= '0;
      cnt_q    <= '0;
      overflow <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      wp_q     <= wp_d;
      rp_q     <= rp_d;
      cnt_q    <= cnt_d;
      overflow <= overflow | ovf_set;
      rd_valid <= pop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rd_data <= '0;
    else if (pop)  rd_data <= mem[rp_q];
  end
endmodule

// File: rtl/strobe_capture_deser.sv
module strobe_capture_deser #(
  parameter int PINS        = 4,
  parameter int SLICES      = 4,
  parameter int DEPTH       = 4,
  parameter int BURST_EDGES = 2 * SLICES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strobe_in,
  input  logic                   gate_en,
  input  logic                   sdr_mode,
  input  logic [PINS-1:0]        pin_data,
  input  logic                   rd_en,
  output logic [PINS*SLICES-1:0] rd_data,
  output logic                   rd_valid,
  output logic                   fifo_empty,
  output logic                   fifo_full,
  output logic                   overflow
);
  localparam int W = PINS * SLICES;

  logic         take, restart, push;
  logic [W-1:0] push_word;

  sgd_gate #(.BURST_EDGES(BURST_EDGES)) u_gate (
    .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in), .gate_en(gate_en),
    .take(take), .restart(restart)
  );

  sgd_assemble #(.PINS(PINS), .SLICES(SLICES)) u_asm (
    .clk(clk), .rst_n(rst_n), .take(take), .restart(restart),
    .sdr_mode(sdr_mode), .pin_data(pin_data),
    .push(push), .push_word(push_word)
  );

  sgd_rfifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_word(push_word),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .empty(fifo_empty), .full(fifo_full), .overflow(overflow)
  );
endmodule

// File: rtl/sgd_checker.sv
module sgd_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         gate_en,
  input logic         rd_en,
  input logic [W-1:0] rd_data,
  input logic         rd_valid,
  input logic         fifo_empty,
  input logic         fifo_full,
  input logic         overflow
);
  AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_empty && fifo_full)); // R9

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9

  AST_FULL_STAYS_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !rd_en) |=> !fifo_empty); // R9

  AST_VALID_NEEDS_POP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(rd_en) && !$past(fifo_empty))); // R8

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data)); // R8

  AST_CLOSED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en && !rd_en) |=> ($stable(fifo_empty) && $stable(fifo_full))); // R2
endmodule

bind strobe_capture_deser sgd_checker #(.W(PINS*SLICES)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .rd_en(rd_en),
  .rd_data(rd_data), .rd_valid(rd_valid), .fifo_empty(fifo_empty),
  .fifo_full(fifo_full), .overflow(overflow)
);

// File: tb/sim_strobe_capture_deser.sv
module sim_strobe_capture_deser;
  localparam int CLK_PERIOD = 10;
  localparam int PINS = 4, SLICES = 4, DEPTH = 4, BURST = 8;
  localparam int W = PINS * SLICES;

  logic clk, rst_n, strobe_in, gate_en, sdr_mode, rd_en;
  logic [PINS-1:0] pin_data;
  logic [W-1:0] rd_data;
  logic rd_valid, fifo_empty, fifo_full, overflow;

  strobe_capture_deser #(.PINS(PINS), .SLICES(SLICES), .DEPTH(DEPTH),
                         .BURST_EDGES(BURST)) u0 (
    .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in), .gate_en(gate_en),
    .sdr_mode(sdr_mode), .pin_data(pin_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .overflow(overflow)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_ps, m_pg, m_odd, m_ovf, m_rvalid;
  int m_left, m_slot;
  logic [W-1:0] m_word, m_rdata;
  logic [W-1:0] q[$];

  always @(posedge clk) begin
    bit er, ef, gr, win, acc, pop;
    if (!rst_n) begin
      m_ps = 0; m_pg = 0; m_odd = 0; m_ovf = 0; m_rvalid = 0;
      m_left = 0; m_slot = 0; m_word = '0; m_rdata = '0; q.delete();
    end else begin
      er = strobe_in && !m_ps;
      ef = !strobe_in && m_ps;
      gr = gate_en && !m_pg;
      if (gr) begin m_slot = 0; m_odd = 0; end
      win = gate_en && (gr || m_left > 0);
      acc = win && (er || ef);
      if (!gate_en) m_left = 0;
      else if (gr) m_left = BURST - (acc ? 1 : 0);
      else if (acc) m_left--;
      pop = rd_en && (q.size() > 0);
      m_rvalid = pop;
      if (pop) m_rdata = q.pop_front();
      if (acc) begin
        if (!(sdr_mode && m_odd)) begin
          m_word[m_slot*PINS +: PINS] = pin_data;
          if (m_slot == SLICES-1) begin
            if (q.size() < DEPTH) q.push_back(m_word);
            else m_ovf = 1;
            m_slot = 0;
          end else m_slot++;
        end
        m_odd = !m_odd;
      end
      m_ps = strobe_in;
      m_pg = gate_en;
    end
  end

  // per-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      chk("R8 rd_valid", W'(rd_valid), W'(m_rvalid));
      chk("R4/R5 rd_data", rd_data, m_rdata);
      chk("R9 overflow", W'(overflow), W'(m_ovf));
      chk("R9 fifo_full", W'(fifo_full), W'(q.size() == DEPTH));
      chk("R7 fifo_empty", W'(fifo_empty), W'(q.size() == 0));
    end
  end

  task automatic strobe_slice(input logic [PINS-1:0] d);
    @(negedge clk);
    pin_data  = d;
    strobe_in = ~strobe_in;
  endtask

  task automatic burst(input int seed, input int n);
    for (int i = 0; i < n; i++) strobe_slice(PINS'(seed + i));
  endtask

  task automatic set_gate(input logic v);
    @(negedge clk);
    gate_en = v;
  endtask

  task automatic read_one(output logic [W-1:0] d, output logic v);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    d = rd_data;
    v = rd_valid;
    rd_en = 1'b0;
  endtask

  task automatic report;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [W-1:0] d;
    logic v;
    rst_n = 0; strobe_in = 0; gate_en = 0; sdr_mode = 0; rd_en = 0; pin_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", W'(fifo_empty), W'(1));
    chk("R1 full", W'(fifo_full), W'(0));
    chk("R1 overflow", W'(overflow), W'(0));
    chk("R1 rd_valid", W'(rd_valid), W'(0));
    chk("R1 rd_data", rd_data, '0);

    // R2 glitches while gate closed
    burst(10, 4);
    repeat (2) @(negedge clk);
    chk("R2 empty after closed-gate edges", W'(fifo_empty), W'(1));

    // R3/R4: 12 edges in one window, only 8 accepted -> two words
    set_gate(1);
    burst(0, 12);
    set_gate(0);
    repeat (2) @(negedge clk);
    read_one(d, v);
    chk("R4 R5 first word", d, 16'h3210);
    chk("R8 valid on pop", W'(v), W'(1));
    read_one(d, v);
    chk("R4 second word", d, 16'h7654);
    read_one(d, v);
    chk("R3 no third word", W'(v), W'(0));
    chk("R8 data held when empty", d, 16'h7654);

    // R6 SDR keeps alternate slices
    sdr_mode = 1;
    set_gate(1);
    burst(1, 8);
    set_gate(0);
    sdr_mode = 0;
    repeat (2) @(negedge clk);
    read_one(d, v);
    chk("R6 sdr word", d, 16'h7531);

    // R10 partial word discarded, R7 same-edge write
    set_gate(1);
    burst(9, 3);
    set_gate(0);
    strobe_slice(4'hF);
    set_gate(1);
    burst(4, 4);
    @(negedge clk);
    chk("R7 word visible at once", W'(fifo_empty), W'(0));
    set_gate(0);
    read_one(d, v);
    chk("R10 partial discarded", d, 16'h7654);

    // R9 fill and overflow: six words, no reads
    for (int b = 0; b < 3; b++) begin
      set_gate(1);
      burst(b * 8, 8);
      set_gate(0);
    end
    repeat (2) @(negedge clk);
    chk("R9 full", W'(fifo_full), W'(1));
    chk("R9 overflow set", W'(overflow), W'(1));
    read_one(d, v);
    chk("R9 oldest kept", d, 16'h3210);
    for (int k = 0; k < 4; k++) read_one(d, v);
    chk("R9 empty after drain", W'(fifo_empty), W'(1));
    chk("R9 overflow sticky", W'(overflow), W'(1));
    repeat (3) @(negedge clk);
    report();
  end
endmodule